// File: doc/BRIEF.md
# Exception Lifecycle State Tracker

This block keeps, for every exception vector of a small-core interrupt controller, four pieces of state: enabled, pending, active, and (for external lines) the last sampled line level. It turns a handful of event sources into updates of that state: rising edges on external interrupt lines, a level-sensitive periodic-timer request, software pend and clear strobes, enable set and clear strobes, the core's acknowledge of the vector that an outside arbiter selected, and the core's return from a handler. Choosing which pending vector wins is left to a separate arbiter that reads the state vectors this block exports.

A software request for a synchronous fault vector is checked against the execution priority that the core supplies, and against the vector's enable. A request that cannot be taken as asked is redirected to hard fault. If even hard fault cannot be taken, because the execution priority is already negative, the block records a lockup instead. When a handler returns, an external vector whose line is still high becomes pending again, so a held line keeps being serviced. A return-to-base flag reports whether at most one handler is active.

All event inputs are single-cycle strobes that are always accepted. There is no back-pressure, and none is needed, because every event is applied in the clock cycle in which it arrives. All state changes become visible on the outputs one clock after the strobe.

Top module: `exc_lifecycle_tracker`

## Requirements
- R1: After reset, vectors 2, 3, 11, 12, 14 and 15 are enabled and all others are disabled. No vector is pending or active. The forced, lockup and illegal-return flags are 0, and return-to-base is 1.
- R2: External line k belongs to vector 16+k. Its pending bit is set one clock after the line is sampled high while the stored level from the previous clock was low. A line that stays high does not pend again.
- R3: A legal return clears the vector's active bit. It sets the pending bit again only when the vector is external (16 or above) and its line is high in the cycle of the return. An internal vector is not re-pended.
- R4: A return naming a vector that is not active, or a vector number beyond the last vector, raises illegal_ret for exactly one clock and changes no enabled, pending or active bit.
- R5: An acknowledge of vector v (v of 2 or more) sets active[v] and clears pending[v] on the next clock.
- R6: A software pend of vector v with 3 ≤ v ≤ 13 is redirected to vector 3 and sets the sticky forced_hard flag when the vector is disabled or its priority is at least exec_prio. Vector 3 has priority -1. The priority of vector 4+i is fault_prio[i*PRIO_W +: PRIO_W], unsigned. Without escalation, vector v itself becomes pending.
- R7: When R6 calls for escalation and exec_prio is negative, no pending bit is set and the sticky lockup flag is raised instead.
- R8: ret_to_base is 1 when zero or one vectors are active, and 0 when two or more are active.
- R9: While timer_trig is high, vector 15 is set pending on every clock, with no edge detection.
- R10: When events meet on one vector in one clock, the precedence is: legal return, then acknowledge, then any pend source, then software clear.
- R11: An enable set or clear changes the enable of vectors 4 and above, and set wins over clear. Writes to vectors 2 and 3 leave them enabled. Writes to vectors 0 and 1 leave them disabled.
- R12: Software pend, software clear and acknowledge take effect only for vector numbers from 2 to NUM_VEC-1. Other numbers leave every pending and active bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_line | input | NUM_EXT | External interrupt lines; bit k maps to vector 16+k |
| timer_trig | input | 1 | Level request for the timer vector (15) |
| pend_set_valid | input | 1 | Software pend strobe |
| pend_set_vec | input | VW | Vector to pend |
| pend_clr_valid | input | 1 | Software clear-pending strobe |
| pend_clr_vec | input | VW | Vector to clear |
| en_set_valid | input | 1 | Enable-set strobe |
| en_set_vec | input | VW | Vector to enable |
| en_clr_valid | input | 1 | Enable-clear strobe |
| en_clr_vec | input | VW | Vector to disable |
| ack_valid | input | 1 | Core acknowledge strobe |
| ack_vec | input | VW | Vector chosen by the arbiter |
| ret_valid | input | 1 | Handler-return strobe |
| ret_vec | input | VW | Vector being returned from |
| exec_prio | input | PRIO_W+2 | Signed current execution priority |
| fault_prio | input | 10*PRIO_W | Priorities of vectors 4..13 |
| vec_enabled | output | NUM_VEC | Per-vector enable |
| vec_pending | output | NUM_VEC | Per-vector pending |
| vec_active | output | NUM_VEC | Per-vector active |
| forced_hard | output | 1 | Sticky: a fault was escalated to hard fault |
| lockup | output | 1 | Sticky: escalation was impossible |
| illegal_ret | output | 1 | One-clock pulse after a rejected return |
| ret_to_base | output | 1 | At most one vector active |

## Verification
The bench builds the block with NUM_EXT=4 and PRIO_W=3. That gives twenty vectors and an execution-priority range of -2 to 8. With priorities this narrow, random fault priorities often equal the execution priority, so the greater-or-equal escalation edge is hit often. Four toggling lines produce frequent edges and coincide with returns. Random vector numbers also land on 0, 1 and beyond the last vector often enough to exercise the ignore rules. A mid-run reset re-arms the sticky lockup and forced flags for the random phase.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int VEC_NMI    = 2;
  localparam int VEC_HARD   = 3;
  localparam int VEC_MEM    = 4;
  localparam int VEC_SVC    = 11;
  localparam int VEC_DEBUG  = 12;
  localparam int VEC_PENDSV = 14;
  localparam int VEC_TIMER  = 15;
  localparam int FIRST_EXT  = 16;
  localparam int FAULT_LO   = VEC_MEM;
  localparam int FAULT_N    = VEC_PENDSV - FAULT_LO;

  function automatic bit reset_enable(int v);
    return (v == VEC_NMI) || (v == VEC_HARD) || (v == VEC_SVC) ||
           (v == VEC_DEBUG) || (v == VEC_PENDSV) || (v == VEC_TIMER);
  endfunction

  function automatic bit fixed_enable(int v);
    return (v == VEC_NMI) || (v == VEC_HARD);
  endfunction
endpackage

// File: rtl/exc_line_edge.sv
module exc_line_edge #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl_q;

  for (genvar k = 0; k < N; k++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[k] <= 1'b0;
      else        lvl_q[k] <= line[k];
    end
    assign rise[k] = line[k] & ~lvl_q[k];

    // a stored level can only produce one edge before it must fall again
    assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rise[k] |=> !rise[k]);
  end
endmodule

// File: rtl/exc_escalate.sv
module exc_escalate #(
  parameter int NUM_VEC = 24,
  parameter int PRIO_W  = 8,
  parameter int VW      = 5
) (
  input  logic                               req_valid,
  input  logic [VW-1:0]                      req_vec,
  input  logic signed [PRIO_W+1:0]           exec_prio,
  input  logic [exc_pkg::FAULT_N*PRIO_W-1:0] fault_prio,
  input  logic [NUM_VEC-1:0]                 en_vec,
  output logic                               out_valid,
  output logic [VW-1:0]                      out_vec,
  output logic                               forced_evt,
  output logic                               lockup_evt
);
  import exc_pkg::*;
  localparam int EPW = PRIO_W + 2;

  logic signed [EPW-1:0] vprio;
  logic en_sel, in_range, is_sync, esc;

  always_comb begin
    in_range = (int'(req_vec) >= VEC_NMI) && (int'(req_vec) < NUM_VEC);
    is_sync  = (int'(req_vec) >= VEC_HARD) && (int'(req_vec) < VEC_PENDSV);
    en_sel = 1'b0;
    for (int v = 0; v < NUM_VEC; v++)
      if (int'(req_vec) == v) en_sel = en_vec[v];
    vprio = '1; // hard fault sits at -1
    for (int i = 0; i < FAULT_N; i++)
      if (int'(req_vec) == FAULT_LO + i)
        vprio = signed'({2'b00, fault_prio[i*PRIO_W +: PRIO_W]});
    esc        = req_valid && in_range && is_sync && ((vprio >= exec_prio) || !en_sel);
    lockup_evt = esc && (exec_prio < 0);
    forced_evt = esc && !lockup_evt;
    out_valid  = req_valid && in_range && !lockup_evt;
    out_vec    = esc ? VW'(VEC_HARD) : req_vec;
  end
endmodule

// File: rtl/exc_vec_slot.sv
module exc_vec_slot #(
  parameter bit IS_EXT   = 1'b0,
  parameter bit RST_EN   = 1'b0,
  parameter bit FIXED_EN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pend,
  input  logic clr_pend,
  input  logic ack_hit,
  input  logic ret_hit,
  input  logic line_hi,
  input  logic en_set,
  input  logic en_clr,
  output logic en_q,
  output logic pend_q,
  output logic act_q,
  output logic ret_ok
);
  logic ack_ok;

  assign ret_ok = ret_hit & act_q;
  assign ack_ok = ack_hit & ~ret_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= RST_EN;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      if (ret_ok) begin
        act_q <= 1'b0;
        if (IS_EXT && line_hi) pend_q <= 1'b1;
      end else if (ack_ok) begin
        act_q  <= 1'b1;
        pend_q <= 1'b0;
      end else if (set_pend) begin
        pend_q <= 1'b1;
      end else if (clr_pend) begin
        pend_q <= 1'b0;
      end
      if (FIXED_EN)    en_q <= 1'b1;
      else if (en_set) en_q <= 1'b1;
      else if (en_clr) en_q <= 1'b0;
    end
  end

  assert_act_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> $past(ack_hit));
  assert_act_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> $past(ret_hit));
  assert_ack_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !act_q) |=> (act_q && !pend_q));
  assert_ret_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_hit && act_q) |=> !act_q);
endmodule

// File: rtl/exc_lifecycle_tracker.sv
module exc_lifecycle_tracker #(
  parameter int  NUM_EXT = 8,
  parameter int  PRIO_W  = 8,
  localparam int NUM_VEC = exc_pkg::FIRST_EXT + NUM_EXT,
  localparam int VW      = $clog2(NUM_VEC),
  localparam int FPW     = exc_pkg::FAULT_N * PRIO_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_EXT-1:0]      ext_line,
  input  logic                    timer_trig,
  input  logic                    pend_set_valid,
  input  logic [VW-1:0]           pend_set_vec,
  input  logic                    pend_clr_valid,
  input  logic [VW-1:0]           pend_clr_vec,
  input  logic                    en_set_valid,
  input  logic [VW-1:0]           en_set_vec,
  input  logic                    en_clr_valid,
  input  logic [VW-1:0]           en_clr_vec,
  input  logic                    ack_valid,
  input  logic [VW-1:0]           ack_vec,
  input  logic                    ret_valid,
  input  logic [VW-1:0]           ret_vec,
  input  logic signed [PRIO_W+1:0] exec_prio,
  input  logic [FPW-1:0]          fault_prio,
  output logic [NUM_VEC-1:0]      vec_enabled,
  output logic [NUM_VEC-1:0]      vec_pending,
  output logic [NUM_VEC-1:0]      vec_active,
  output logic                    forced_hard,
  output logic                    lockup,
  output logic                    illegal_ret,
  output logic                    ret_to_base
);
  import exc_pkg::*;

  logic [NUM_EXT-1:0] rise;
  logic               sw_valid;
  logic [VW-1:0]      sw_vec;
  logic               forced_evt, lockup_evt;
  logic [NUM_VEC-1:0] ret_ok;

  exc_line_edge #(.N(NUM_EXT)) u_edge (
    .clk(clk), .rst_n(rst_n), .line(ext_line), .rise(rise)
  );

  exc_escalate #(.NUM_VEC(NUM_VEC), .PRIO_W(PRIO_W), .VW(VW)) u_esc (
    .req_valid(pend_set_valid), .req_vec(pend_set_vec), .exec_prio(exec_prio),
    .fault_prio(fault_prio), .en_vec(vec_enabled),
    .out_valid(sw_valid), .out_vec(sw_vec),
    .forced_evt(forced_evt), .lockup_evt(lockup_evt)
  );

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    localparam bit TGT = (v >= VEC_NMI);
    localparam bit CFG = (v >= VEC_MEM);
    logic ext_rise, line_h, set_p, clr_p, ack_h, ret_h, en_s, en_c;

    if (v >= FIRST_EXT) begin : g_ext
      assign ext_rise = rise[v-FIRST_EXT];
      assign line_h   = ext_line[v-FIRST_EXT];
    end else begin : g_int
      assign ext_rise = 1'b0;
      assign line_h   = 1'b0;
    end

    assign set_p = TGT && ((sw_valid && sw_vec == VW'(v)) ||
                           ((v == VEC_TIMER) && timer_trig) || ext_rise);
    assign clr_p = TGT && pend_clr_valid && (pend_clr_vec == VW'(v));
    assign ack_h = TGT && ack_valid && (ack_vec == VW'(v));
    assign ret_h = ret_valid && (ret_vec == VW'(v));
    assign en_s  = CFG && en_set_valid && (en_set_vec == VW'(v));
    assign en_c  = CFG && en_clr_valid && (en_clr_vec == VW'(v));

    exc_vec_slot #(
      .IS_EXT(v >= FIRST_EXT), .RST_EN(reset_enable(v)), .FIXED_EN(fixed_enable(v))
    ) u_slot (
      .clk(clk), .rst_n(rst_n), .set_pend(set_p), .clr_pend(clr_p),
      .ack_hit(ack_h), .ret_hit(ret_h), .line_hi(line_h),
      .en_set(en_s), .en_clr(en_c),
      .en_q(vec_enabled[v]), .pend_q(vec_pending[v]), .act_q(vec_active[v]),
      .ret_ok(ret_ok[v])
    );
  end

  assign ret_to_base = ((vec_active & (vec_active - 1'b1)) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      forced_hard <= 1'b0;
      lockup      <= 1'b0;
      illegal_ret <= 1'b0;
    end else begin
      forced_hard <= forced_hard | forced_evt;
      lockup      <= lockup | lockup_evt;
      illegal_ret <= ret_valid && !(|ret_ok);
    end
  end

  assert_lockup_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockup) |-> ($past(pend_set_valid) && ($past(exec_prio) < 0)));
  assert_forced_pends_hard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(forced_hard) && !$past(ret_valid && ret_vec == VW'(VEC_HARD)))
      |-> (vec_pending[VEC_HARD] || vec_active[VEC_HARD]));
  assert_illegal_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_ret |-> $past(ret_valid));
  assert_timer_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_trig && !(ret_valid && ret_vec == VW'(VEC_TIMER)) &&
     !(ack_valid && ack_vec == VW'(VEC_TIMER))) |=> vec_pending[VEC_TIMER]);
endmodule

// File: tb/exc_lifecycle_tracker_tb.sv
module exc_lifecycle_tracker_tb;
  localparam int NE  = 4;
  localparam int PW  = 3;
  localparam int NV  = 16 + NE;
  localparam int VW  = $clog2(NV);
  localparam int EPW = PW + 2;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [NE-1:0] ln = '0;
  logic tmr = 0, ps_v = 0, pc_v = 0, es_v = 0, ec_v = 0, ak_v = 0, rt_v = 0;
  logic [VW-1:0] ps_n = '0, pc_n = '0, es_n = '0, ec_n = '0, ak_n = '0, rt_n = '0;
  logic signed [EPW-1:0] ex = 8;
  logic [10*PW-1:0] fp = '0;

  logic [NV-1:0] vec_enabled, vec_pending, vec_active;
  logic forced_hard, lockup, illegal_ret, ret_to_base;

  exc_lifecycle_tracker #(.NUM_EXT(NE), .PRIO_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_line(ln), .timer_trig(tmr),
    .pend_set_valid(ps_v), .pend_set_vec(ps_n), .pend_clr_valid(pc_v), .pend_clr_vec(pc_n),
    .en_set_valid(es_v), .en_set_vec(es_n), .en_clr_valid(ec_v), .en_clr_vec(ec_n),
    .ack_valid(ak_v), .ack_vec(ak_n), .ret_valid(rt_v), .ret_vec(rt_n),
    .exec_prio(ex), .fault_prio(fp),
    .vec_enabled(vec_enabled), .vec_pending(vec_pending), .vec_active(vec_active),
    .forced_hard(forced_hard), .lockup(lockup), .illegal_ret(illegal_ret),
    .ret_to_base(ret_to_base)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  logic [NV-1:0] m_en, m_pend, m_act;
  logic [NE-1:0] m_lvl;
  logic m_forced, m_lock, m_ill;

  task automatic chk(string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", what, got, exp);
    end
  endtask

  task automatic model_reset();
    m_en = '0;
    m_en[2] = 1; m_en[3] = 1; m_en[11] = 1; m_en[12] = 1; m_en[14] = 1; m_en[15] = 1;
    m_pend = '0; m_act = '0; m_lvl = '0;
    m_forced = 0; m_lock = 0; m_ill = 0;
  endtask

  // expected next state, written from the requirement list
  task automatic model_step();
    logic [NV-1:0] setv;
    int t, p;
    setv = '0;
    m_ill = rt_v && !((int'(rt_n) < NV) && m_act[rt_n]);
    if (ps_v && int'(ps_n) >= 2 && int'(ps_n) < NV) begin
      t = int'(ps_n);
      if (t >= 3 && t <= 13) begin
        p = (t == 3) ? -1 : int'(fp[(t-4)*PW +: PW]);
        if (p >= int'(ex) || !m_en[t]) begin
          if (int'(ex) < 0) begin m_lock = 1; t = -1; end
          else begin m_forced = 1; t = 3; end
        end
      end
      if (t >= 0) setv[t] = 1;
    end
    if (tmr) setv[15] = 1;
    for (int k = 0; k < NE; k++) if (ln[k] && !m_lvl[k]) setv[16+k] = 1;
    for (int v = 0; v < NV; v++) begin
      if (rt_v && int'(rt_n) == v && m_act[v]) begin
        m_act[v] = 0;
        if (v >= 16 && ln[v-16]) m_pend[v] = 1;
      end else if (v >= 2 && ak_v && int'(ak_n) == v) begin
        m_act[v] = 1; m_pend[v] = 0;
      end else if (setv[v]) m_pend[v] = 1;
      else if (v >= 2 && pc_v && int'(pc_n) == v) m_pend[v] = 0;
      if (v >= 4) begin
        if (es_v && int'(es_n) == v) m_en[v] = 1;
        else if (ec_v && int'(ec_n) == v) m_en[v] = 0;
      end
    end
    m_lvl = ln;
  endtask

  task automatic compare_all(string tag);
    chk({tag, " enabled R11"}, 64'(vec_enabled), 64'(m_en));
    chk({tag, " pending R12"}, 64'(vec_pending), 64'(m_pend));
    chk({tag, " active R5"}, 64'(vec_active), 64'(m_act));
    chk({tag, " forced R6"}, 64'(forced_hard), 64'(m_forced));
    chk({tag, " lockup R7"}, 64'(lockup), 64'(m_lock));
    chk({tag, " illegal R4"}, 64'(illegal_ret), 64'(m_ill));
    chk({tag, " rtb R8"}, 64'(ret_to_base), 64'($countones(m_act) <= 1));
  endtask

  task automatic idle();
    ps_v = 0; pc_v = 0; es_v = 0; ec_v = 0; ak_v = 0; rt_v = 0;
  endtask

  task automatic go(string tag);
    model_step();
    @(negedge clk);
    compare_all(tag);
    idle();
  endtask

  task automatic do_reset();
    rst_n = 0; idle(); ln = '0; tmr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    compare_all("R1 reset");
    chk("R1 enable pattern", 64'(vec_enabled), 64'h0D80C);
    chk("R1 ret_to_base", 64'(ret_to_base), 64'd1);

    ln[0] = 1; go("R2 edge");
    chk("R2 pend on edge", 64'(vec_pending[16]), 64'd1);
    pc_v = 1; pc_n = 16; go("R2 clear");
    go("R2 held");
    chk("R2 held line no repend", 64'(vec_pending[16]), 64'd0);

    ps_v = 1; ps_n = 16; go("R5 pend");
    ak_v = 1; ak_n = 16; go("R5 ack");
    chk("R5 active set", 64'(vec_active[16]), 64'd1);
    chk("R5 pending cleared", 64'(vec_pending[16]), 64'd0);

    rt_v = 1; rt_n = 16; go("R3 return high");
    chk("R3 repend external", 64'(vec_pending[16]), 64'd1);
    ak_v = 1; ak_n = 16; go("R3 ack");
    ln[0] = 0; rt_v = 1; rt_n = 16; go("R3 return low");
    chk("R3 no repend low", 64'(vec_pending[16]), 64'd0);
    ps_v = 1; ps_n = 14; go("R3 int pend");
    ak_v = 1; ak_n = 14; go("R3 int ack");
    rt_v = 1; rt_n = 14; go("R3 int ret");
    chk("R3 internal not repended", 64'(vec_pending[14]), 64'd0);

    rt_v = 1; rt_n = 19; go("R4 bad ret");
    chk("R4 illegal pulse", 64'(illegal_ret), 64'd1);
    go("R4 after");
    chk("R4 pulse ends", 64'(illegal_ret), 64'd0);

    ex = 2; fp[0 +: PW] = 5; es_v = 1; es_n = 4; go("R6 enable mem");
    ps_v = 1; ps_n = 4; go("R6 prio");
    chk("R6 escalated to hard", 64'(vec_pending[3]), 64'd1);
    chk("R6 source not pended", 64'(vec_pending[4]), 64'd0);
    chk("R6 forced", 64'(forced_hard), 64'd1);
    pc_v = 1; pc_n = 3; go("R6 clr");
    ex = 8; fp[PW +: PW] = 0; ps_v = 1; ps_n = 5; go("R6 disabled");
    chk("R6 disabled escalates", 64'(vec_pending[3]), 64'd1);
    pc_v = 1; pc_n = 3; go("R6 clr2");
    fp[0 +: PW] = 1; ex = 4; ps_v = 1; ps_n = 4; go("R6 no escalation");
    chk("R6 plain pend", 64'(vec_pending[4]), 64'd1);
    pc_v = 1; pc_n = 4; go("R6 clr3");

    ex = -1; ps_v = 1; ps_n = 6; go("R7 lockup");
    chk("R7 lockup flag", 64'(lockup), 64'd1);
    chk("R7 nothing pended", 64'({vec_pending[6], vec_pending[3]}), 64'd0);
    ex = 8;

    tmr = 1; pc_v = 1; pc_n = 15; go("R10 set beats clear");
    chk("R10 timer set over clear", 64'(vec_pending[15]), 64'd1);
    pc_v = 1; pc_n = 15; go("R9 level");
    chk("R9 level repends", 64'(vec_pending[15]), 64'd1);
    tmr = 0; pc_v = 1; pc_n = 15; go("R9 drop");
    chk("R9 clears when low", 64'(vec_pending[15]), 64'd0);

    ps_v = 1; ps_n = 17; ak_v = 1; ak_n = 17; go("R10 ack vs pend");
    chk("R10 ack wins active", 64'(vec_active[17]), 64'd1);
    chk("R10 ack wins pending", 64'(vec_pending[17]), 64'd0);
    ak_v = 1; ak_n = 17; rt_v = 1; rt_n = 17; go("R10 ret vs ack");
    chk("R10 return wins", 64'(vec_active[17]), 64'd0);

    ak_v = 1; ak_n = 14; go("R8 one");
    chk("R8 one active", 64'(ret_to_base), 64'd1);
    ak_v = 1; ak_n = 18; go("R8 two");
    chk("R8 two active", 64'(ret_to_base), 64'd0);
    rt_v = 1; rt_n = 14; go("R8 back");
    chk("R8 back to one", 64'(ret_to_base), 64'd1);
    rt_v = 1; rt_n = 18; go("R8 zero");

    ec_v = 1; ec_n = 2; go("R11 fixed");
    chk("R11 nmi stays enabled", 64'(vec_enabled[2]), 64'd1);
    es_v = 1; es_n = 7; ec_v = 1; ec_n = 7; go("R11 set wins");
    chk("R11 set over clear", 64'(vec_enabled[7]), 64'd1);
    ec_v = 1; ec_n = 7; go("R11 clear");
    chk("R11 cleared", 64'(vec_enabled[7]), 64'd0);

    ps_v = 1; ps_n = 1; go("R12 vec1");
    chk("R12 vec1 ignored", 64'(vec_pending[1]), 64'd0);
    ps_v = 1; ps_n = 21; ak_v = 1; ak_n = 0; go("R12 out of range");

    do_reset();
    compare_all("R1 second reset");
    for (int c = 0; c < 3000; c++) begin
      for (int k = 0; k < NE; k++) if ($urandom % 100 < 15) ln[k] = ~ln[k];
      tmr  = ($urandom % 100) < 10;
      ps_v = ($urandom % 100) < 30; ps_n = VW'($urandom % (NV + 3));
      pc_v = ($urandom % 100) < 15; pc_n = VW'($urandom % NV);
      es_v = ($urandom % 100) < 10; es_n = VW'($urandom % NV);
      ec_v = ($urandom % 100) < 8;  ec_n = VW'($urandom % NV);
      ak_v = ($urandom % 100) < 20; ak_n = VW'($urandom % (NV + 1));
      rt_v = ($urandom % 100) < 20; rt_n = VW'($urandom % (NV + 2));
      case ($urandom % 8)
        0: ex = -2;
        1: ex = -1;
        2: ex = 0;
        default: ex = EPW'($urandom % 9);
      endcase
      if (c % 50 == 0) fp = 30'($urandom);
      go("RND");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule